// File: doc/BRIEF.md
# Dual-Mode GPIO Port with Rising-Edge Interrupt

A memory-mapped general-purpose I/O port of up to 32 pins. A build-time parameter fixes each instance as either an output port or an input port. As an output port, a bus write to the output register drives the pins, which reset to a configurable pattern. As an input port, pin levels pass through a two-flop synchronizer. They are then captured into a read-only input register under a per-pin enable vector that arrives from outside the block. Each rising transition of a stored bit produces a one-clock interrupt pulse.

The enable vector is registered inside the block, and that register clears on reset. When an enable bit drops, the matching stored bit is cleared. An enabled pin updates its stored bit only when the pin changes level. A pin that is already high when it becomes enabled therefore stays at zero until its next transition. Reads are combinational from the address presented with the request.

Top module: `dual_gpio`

## Requirements
- R1: Parameter IS_INPUT selects the mode and defaults to 0 (output). In input mode, writes to the output register leave pins_o at zero. In output mode, the input register reads zero and irq_o never rises.
- R2: In output mode, a write (req_i=1, we_i=1) to address 0x00 sets pins_o to wdata_i[NUM_PINS-1:0] one clock after the write edge.
- R3: A read (req_i=1, we_i=0) of address 0x00 returns zero in rdata_o in the same cycle.
- R4: A read of address 0x20 returns the input register, zero-extended, in the same cycle. Bus writes to 0x20 leave it unchanged. Bits 4, 5, 20 and 21 always read zero.
- R5: When a synchronized pin changes level and its enable bit is set, its stored bit takes the new level 3 clocks after the pin changes. Changes on disabled pins are ignored. Enabling a pin whose level is steady does not capture that level.
- R6: irq_o is high for exactly one clock, in the same cycle a stored bit first reads 1 after a 0-to-1 change. A 1-to-0 change gives no pulse. Bits rising in the same cycle give one pulse.
- R7: When an enable bit in en_mask_i drops, the stored bit reads zero 2 clocks later.
- R8: While rst_ni is low, pins_o equals OUT_INIT (output mode), and the input register, the internal enable register and irq_o are zero.
- R9: Reads of any address other than 0x00 and 0x20 return zero. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pins_i | input | NUM_PINS | Pin levels, asynchronous |
| pins_o | output | NUM_PINS | Driven pin levels |
| en_mask_i | input | NUM_PINS | Per-pin capture enable |
| irq_o | output | 1 | One-clock pulse on a stored rising bit |

## Verification
A stuck or stale input-register bit shows on the next read of 0x20. A wrong edge register shows as a missing or doubled irq_o pulse, exactly 3 clocks after the pin moves. A lost enable-clear shows 2 clocks after the mask bit drops, when the stored bit still reads one. A wrong output register shows on pins_o one clock after the write, and again at reset as a value other than the initial pattern.

// File: rtl/dual_gpio_pkg.sv
package dual_gpio_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned OUT_OFS = 'h00;
  localparam int unsigned IN_OFS  = 'h20;
  localparam logic [BUS_W-1:0] IN_RSVD = 32'h0030_0030;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/gpio_in_capture.sv
module gpio_in_capture #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] gpi_o,
  output logic         irq_o
);
  logic [W-1:0] pin_s, pin_q, en_q, gpi_q, gpi_d, chg;
  logic         irq_q;

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pin_s)
  );

  assign chg = pin_s ^ pin_q;
  // only a level change is captured; a disabled bit is forced low
  assign gpi_d = en_q & KEEP & ((chg & pin_s) | (~chg & gpi_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= '0;
      en_q  <= '0;
      gpi_q <= '0;
      irq_q <= 1'b0;
    end else begin
      pin_q <= pin_s;
      en_q  <= en_i;
      gpi_q <= gpi_d;
      irq_q <= |(gpi_d & ~gpi_q);
    end
  end

  assign gpi_o = gpi_q;
  assign irq_o = irq_q;

  assert_irq_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ((gpi_q & ~$past(gpi_q)) != '0));

  assert_rise_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> ((gpi_q & ~$past(gpi_q) & ~$past(en_i, 2)) == '0));

  assert_hold_without_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pin_s) == $past(pin_q)) |-> (gpi_q == ($past(gpi_q) & $past(en_q))));

  assert_drop_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gpi_q & ~$past(en_i, 2)) == '0) || !$past(rst_ni, 2) || !$past(rst_ni));
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= INIT;
    else if (wr_i) q_o <= d_i;
  end
endmodule

// File: rtl/dual_gpio.sv
module dual_gpio
  import dual_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter bit          IS_INPUT = 1'b0,
  parameter logic [31:0] OUT_INIT = 32'h0,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] pins_o,
  input  logic [NUM_PINS-1:0] en_mask_i,
  output logic                irq_o
);
  localparam logic [BUS_W-1:0]    PIN_SPAN = {BUS_W{1'b1}} >> (BUS_W - NUM_PINS);
  localparam logic [BUS_W-1:0]    KEEP_W   = PIN_SPAN & ~IN_RSVD;
  localparam logic [NUM_PINS-1:0] KEEP     = KEEP_W[NUM_PINS-1:0];
  localparam logic [ADDR_W-1:0]   A_OUT    = ADDR_W'(OUT_OFS);
  localparam logic [ADDR_W-1:0]   A_IN     = ADDR_W'(IN_OFS);

  initial begin
    if (NUM_PINS < 1 || NUM_PINS > 32) $error("NUM_PINS out of range");
  end

  logic                out_wr, in_rd;
  logic [NUM_PINS-1:0] out_q, gpi, en_gated;

  assign out_wr   = req_i && we_i && (addr_i == A_OUT) && !IS_INPUT;
  assign in_rd    = req_i && !we_i && (addr_i == A_IN);
  assign en_gated = en_mask_i & {NUM_PINS{IS_INPUT}};

  gpio_out_reg #(.W(NUM_PINS), .INIT(OUT_INIT[NUM_PINS-1:0])) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (out_wr),
    .d_i   (wdata_i[NUM_PINS-1:0]),
    .q_o   (out_q)
  );

  gpio_in_capture #(.W(NUM_PINS), .KEEP(KEEP)) u_in (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins_i),
    .en_i  (en_gated),
    .gpi_o (gpi),
    .irq_o (irq_o)
  );

  assign pins_o  = IS_INPUT ? '0 : out_q;
  assign rdata_o = in_rd ? BUS_W'(gpi) : '0;

  assert_out_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && we_i && addr_i == A_OUT) |->
      (pins_o == (IS_INPUT ? '0 : $past(wdata_i[NUM_PINS-1:0]))));

  assert_other_write_no_effect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(req_i && we_i && addr_i == A_OUT)) |-> $stable(pins_o));
endmodule

// File: tb/dual_gpio_bench.sv
module dual_gpio_bench;
  localparam int CLK_NS = 10;
  localparam logic [31:0] INIT = 32'h0000_00A5;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        o_req = 0, o_we = 0, i_req = 1, i_we = 0;
  logic [7:0]  o_addr = 0, i_addr = 8'h20;
  logic [31:0] o_wdata = 0, i_wdata = 0, o_rdata, i_rdata;
  logic [31:0] o_pins_in = 0, i_pins = 0, o_mask = 0, i_mask = 0;
  logic [31:0] o_pins, i_pins_o;
  logic        o_irq, i_irq;

  dual_gpio #(.OUT_INIT(INIT)) u_dual_gpio (
    .clk_i(clk), .rst_ni(rst_n), .req_i(o_req), .we_i(o_we), .addr_i(o_addr),
    .wdata_i(o_wdata), .rdata_o(o_rdata), .pins_i(o_pins_in), .pins_o(o_pins),
    .en_mask_i(o_mask), .irq_o(o_irq)
  );

  dual_gpio #(.IS_INPUT(1'b1), .OUT_INIT(INIT)) u_dual_gpio_in (
    .clk_i(clk), .rst_ni(rst_n), .req_i(i_req), .we_i(i_we), .addr_i(i_addr),
    .wdata_i(i_wdata), .rdata_o(i_rdata), .pins_i(i_pins), .pins_o(i_pins_o),
    .en_mask_i(i_mask), .irq_o(i_irq)
  );

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  item_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return o_pins;
      1: return o_rdata;
      2: return i_pins_o;
      3: return i_rdata;
      4: return 32'(i_irq);
      default: return 32'(o_irq);
    endcase
  endfunction

  task automatic expect_at(int due, int sel, logic [31:0] exp, string tag);
    item_t it;
    int pos;
    it.due = due; it.sel = sel; it.exp = exp; it.tag = tag;
    pos = sb.size();
    for (int k = 0; k < sb.size(); k++)
      if (sb[k].due > due) begin pos = k; break; end
    sb.insert(pos, it);
  endtask

  // monitor: compares due items away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = observe(it.sel);
      checks++;
      if (it.due != cyc || act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h", it.tag, it.sel, cyc, act, it.exp);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c;
    tick(3);
    #2 rst_n = 1;
    tick();
    // R8 reset state
    expect_at(cyc, 0, INIT, "R8 out pins init");
    expect_at(cyc, 3, 32'h0, "R8 input reg zero");
    expect_at(cyc, 4, 32'h0, "R8 irq low");
    tick();
    // R2 write drives pins
    o_req = 1; o_we = 1; o_addr = 8'h00; o_wdata = 32'h1234_5678;
    expect_at(cyc + 1, 0, 32'h1234_5678, "R2 write drives pins");
    tick();
    // R3 read of output register
    o_we = 0;
    expect_at(cyc, 1, 32'h0, "R3 out reg reads zero");
    tick();
    // R9 write elsewhere, read elsewhere
    o_we = 1; o_addr = 8'h44; o_wdata = 32'hFFFF_FFFF;
    expect_at(cyc + 1, 0, 32'h1234_5678, "R9 stray write no effect");
    tick();
    o_we = 0;
    expect_at(cyc, 1, 32'h0, "R9 stray read zero");
    tick();
    // R1 output instance input reg reads zero
    o_addr = 8'h20; o_pins_in = 32'hFFFF_FFFF; o_mask = 32'hFFFF_FFFF;
    expect_at(cyc + 3, 1, 32'h0, "R1 output mode input reg zero");
    expect_at(cyc + 3, 5, 32'h0, "R1 output mode no irq");
    tick(4);
    o_req = 0;
    // R1 input instance ignores output write
    i_we = 1; i_addr = 8'h00; i_wdata = 32'hFFFF_FFFF;
    expect_at(cyc + 1, 2, 32'h0, "R1 input mode pins not driven");
    tick();
    i_we = 0; i_addr = 8'h20;
    // R5 disabled pin ignored
    tick(); c = cyc;
    i_pins[0] = 1'b1;
    expect_at(c + 3, 3, 32'h0, "R5 disabled pin ignored");
    expect_at(c + 3, 4, 32'h0, "R5 disabled no irq");
    tick(5);
    // R5 enabling a steady-high pin captures nothing
    i_mask = 32'hFFFF_FFFF;
    expect_at(cyc + 3, 3, 32'h0, "R5 steady level not captured");
    tick(4); c = cyc;
    // R5/R6 single rise
    i_pins[1] = 1'b1;
    expect_at(c + 2, 3, 32'h0, "R5 not yet captured");
    expect_at(c + 2, 4, 32'h0, "R6 irq before rise");
    expect_at(c + 3, 3, 32'h2, "R5 enabled rise captured");
    expect_at(c + 3, 4, 32'h1, "R6 irq pulse");
    expect_at(c + 4, 4, 32'h0, "R6 irq one clock");
    tick(5); c = cyc;
    // R6 falling edge gives no irq
    i_pins[1] = 1'b0;
    expect_at(c + 3, 3, 32'h0, "R5 fall captured");
    expect_at(c + 3, 4, 32'h0, "R6 fall no irq");
    expect_at(c + 4, 4, 32'h0, "R6 fall no irq later");
    tick(5); c = cyc;
    // R4 reserved bits
    i_pins[4] = 1'b1; i_pins[20] = 1'b1;
    expect_at(c + 3, 3, 32'h0, "R4 reserved bits zero");
    expect_at(c + 3, 4, 32'h0, "R4 reserved no irq");
    tick(5); c = cyc;
    // R6 simultaneous rises
    i_pins[2] = 1'b1; i_pins[3] = 1'b1;
    expect_at(c + 3, 3, 32'hC, "R6 two bits captured");
    expect_at(c + 3, 4, 32'h1, "R6 one pulse for two bits");
    expect_at(c + 4, 4, 32'h0, "R6 single pulse ends");
    tick(5);
    // R4 bus write to input register ignored
    i_we = 1; i_wdata = 32'h0;
    tick();
    i_we = 0;
    expect_at(cyc, 3, 32'hC, "R4 write to input reg ignored");
    tick(); c = cyc;
    // R7 disable clears bit
    i_mask = ~32'h4;
    expect_at(c + 1, 3, 32'hC, "R7 bit still set");
    expect_at(c + 2, 3, 32'h8, "R7 disabled bit cleared");
    expect_at(c + 2, 4, 32'h0, "R7 clear no irq");
    tick(4); c = cyc;
    // R5 re-enable steady pin not recaptured
    i_mask = 32'hFFFF_FFFF;
    expect_at(c + 3, 3, 32'h8, "R5 re-enable no capture");
    tick(5);
    // R8 reset mid-run
    rst_n = 0;
    tick(2);
    expect_at(cyc, 0, INIT, "R8 out pins reload");
    expect_at(cyc, 3, 32'h0, "R8 input reg cleared");
    expect_at(cyc, 4, 32'h0, "R8 irq cleared");
    tick();
    #2 rst_n = 1;
    tick(4);
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule